// File: doc/BRIEF.md
# Debug-Port Security Unlock Controller

This block decides which commands a debug port may run against a non-volatile memory controller, based on whether the device is secured. While the device is secured, the debug port may only ask for four things. It can check that every block is blank, erase every block, remove write protection, or run a one-step unsecure. Any other request is refused with a one-cycle access-error pulse. The only way to unlock is to erase everything. The port then either proves the erase with a passing blank check or uses the one-step unsecure, which erases and unlocks together.

The memory array is modelled as one "erased" flag per block, and a stored 8-bit security byte. Both survive a system reset and are cleared only by power-on reset. After every system reset, the controller runs a fixed-length start-up phase with the command-complete flag low. It then loads the security state from bits [1:0] of the stored byte. Only the pattern 2'b10 means unsecured. A debug session that has unlocked the device can therefore program the byte so that later resets come up open.

The controller is a four-state machine:
- INIT: start-up, leaves to IDLE when the start-up timer expires.
- IDLE: ready, command-complete high.
- VERIFY: one-cycle blank check, always returns to IDLE.
- ERASE: timed mass erase, returns to IDLE when the erase timer expires.

IDLE goes to VERIFY on an accepted blank check, and to ERASE on an accepted mass erase or one-step unsecure. Every other accepted command completes in IDLE.

Top module: `dbg_sec_unlock`

## Requirements
- R1: After a system reset, `cmd_done` is low for INIT_CYC cycles and then goes high. At that point `prot_on` is 1, `verify_pass` is 0 and `secured` is 0 only if `sec_byte[1:0]` equals 2'b10.
- R2: While `secured` is 1, only codes 1 (blank check), 2 (mass erase), 3 (clear protection) and 4 (one-step unsecure) are accepted. Codes 5, 6 and 7 give `acc_err` high for exactly the cycle after the request and change no other output.
- R3: Codes 2 and 4 issued while `prot_on` is 1 are refused with the `acc_err` pulse, and the blocks, the security byte and `secured` do not change.
- R4: An accepted code 2 holds `cmd_done` low for ERASE_CYC cycles. After that every `blk_erased` bit is 1 and `sec_byte` is 8'hFF, and `secured` does not change.
- R5: An accepted code 1 holds `cmd_done` low for one cycle. It then sets `verify_pass` to the AND of all `blk_erased` bits, and clears `secured` only when that AND is 1.
- R6: An accepted code 4 behaves like code 2 in timing and block effect. When it completes, it clears `secured` and writes `sec_byte` to 8'hFE.
- R7: While unsecured, code 5 clears `blk_erased[cmd_data]`, code 6 writes `cmd_data` into `sec_byte`, and code 7 sets `prot_on`. Each takes effect one cycle after the request, with `cmd_done` staying high. Code 3 clears `prot_on` in the same way in either security state.
- R8: A request made while `cmd_done` is low is ignored and gives an `acc_err` pulse the following cycle.
- R9: `blk_erased` and `sec_byte` keep their values across `rst_n`. `por_n` low sets `blk_erased` to all zeros and `sec_byte` to 8'h00, and also restarts the start-up phase.
- R10: Code 0 is refused with the `acc_err` pulse in every security state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears the stored array model |
| rst_n | input | 1 | System reset, active low, restarts start-up |
| cmd_valid | input | 1 | Debug command request, one cycle |
| cmd_code | input | 3 | Command code (0 to 7) |
| cmd_data | input | 8 | Block index for code 5, byte value for code 6 |
| cmd_done | output | 1 | Command complete, high when a new command may be issued |
| acc_err | output | 1 | One-cycle pulse for a refused request |
| secured | output | 1 | Device is secured |
| prot_on | output | 1 | Write protection is active |
| verify_pass | output | 1 | Result of the last blank check |
| blk_erased | output | NBLK | Per-block erased flags |
| sec_byte | output | 8 | Stored security byte |

## Verification
If a request is driven in cycle c, its refusal pulse, and the effect of a command that completes in IDLE, both appear in cycle c+1. A refusal pulse is gone again in cycle c+2. A blank check shows `cmd_done` low in c+1 and its result in c+2. An erase or one-step unsecure shows `cmd_done` low in c+1 through c+ERASE_CYC and its result in c+ERASE_CYC+1. After reset is released in cycle r, `cmd_done` is still low in r+INIT_CYC-1 and high, with the loaded security state, in r+INIT_CYC. The driver tags each expected output snapshot with its due cycle and queues it. The monitor compares each snapshot on the falling edge of exactly that cycle, and reports any snapshot whose cycle has passed.

// File: rtl/dsu_pkg.sv
`timescale 1ns/1ps
package dsu_pkg;
    typedef enum logic [2:0] {
        CMD_NONE       = 3'd0,
        CMD_VERIFY_ALL = 3'd1,
        CMD_ERASE_ALL  = 3'd2,
        CMD_CLR_PROT   = 3'd3,
        CMD_UNSECURE   = 3'd4,
        CMD_PROG_BLK   = 3'd5,
        CMD_PROG_SEC   = 3'd6,
        CMD_SET_PROT   = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        ST_INIT,
        ST_IDLE,
        ST_VERIFY,
        ST_ERASE
    } state_e;

    localparam logic [1:0] SEC_FIELD_OPEN  = 2'b10;
    localparam logic [7:0] SEC_BYTE_BLANK  = 8'hFF;
    localparam logic [7:0] SEC_BYTE_OPEN   = 8'hFE;
    localparam logic [7:0] SEC_BYTE_POR    = 8'h00;
endpackage

// File: rtl/dsu_cmd_filter.sv
`timescale 1ns/1ps
// Permission decode for a debug command (R2, R3, R10)
module dsu_cmd_filter
    import dsu_pkg::*;
(
    input  cmd_e cmd,
    input  logic secured,
    input  logic prot_on,
    output logic permitted
);
    always_comb begin
        permitted = 1'b1;
        unique case (cmd)
            CMD_NONE:                     permitted = 1'b0;               // R10
            CMD_VERIFY_ALL, CMD_CLR_PROT: permitted = 1'b1;
            CMD_ERASE_ALL, CMD_UNSECURE:  permitted = !prot_on;           // R3
            CMD_PROG_BLK, CMD_PROG_SEC,
            CMD_SET_PROT:                 permitted = !secured;           // R2
            default:                      permitted = 1'b0;
        endcase
    end
endmodule

// File: rtl/dsu_busy_timer.sv
`timescale 1ns/1ps
// Down-counter shared by the start-up and erase phases
module dsu_busy_timer #(
    parameter int CNT_W   = 4,
    parameter int RST_VAL = 3,
    parameter int MAX_VAL = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= CNT_W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R4: the counter never exceeds the longest phase it is used for
    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_VAL));
endmodule

// File: rtl/dsu_nv_store.sv
`timescale 1ns/1ps
// Stored array model: per-block erased flags and the security byte (R9)
module dsu_nv_store
    import dsu_pkg::*;
#(
    parameter int NBLK   = 4,
    parameter int BIDX_W = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              erase_all,
    input  logic              erase_open,
    input  logic              prog_blk,
    input  logic [BIDX_W-1:0] blk_idx,
    input  logic              prog_sec,
    input  logic [7:0]        sec_data,
    output logic [NBLK-1:0]   blk_erased,
    output logic [7:0]        sec_byte
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            blk_erased <= '0;
            sec_byte   <= SEC_BYTE_POR;
        end else if (erase_all) begin
            blk_erased <= '1;
            sec_byte   <= erase_open ? SEC_BYTE_OPEN : SEC_BYTE_BLANK;
        end else begin
            if (prog_blk && (int'(blk_idx) < NBLK))
                blk_erased[blk_idx] <= 1'b0;
            if (prog_sec)
                sec_byte <= sec_data;
        end
    end

    // R4: a finished mass erase leaves every block blank
    assert_erase_fills_R4: assert property (@(posedge clk) disable iff (!por_n)
        erase_all |=> (&blk_erased));
endmodule

// File: rtl/dbg_sec_unlock.sv
`timescale 1ns/1ps
module dbg_sec_unlock
    import dsu_pkg::*;
#(
    parameter int NBLK      = 4,
    parameter int INIT_CYC  = 4,
    parameter int ERASE_CYC = 8
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_code,
    input  logic [7:0]      cmd_data,
    output logic            cmd_done,
    output logic            acc_err,
    output logic            secured,
    output logic            prot_on,
    output logic            verify_pass,
    output logic [NBLK-1:0] blk_erased,
    output logic [7:0]      sec_byte
);
    localparam int MAX_CYC = (INIT_CYC > ERASE_CYC) ? INIT_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int BIDX_W  = (NBLK > 1) ? $clog2(NBLK) : 1;

    logic   sys_rst_n;
    state_e state, state_nx;
    cmd_e   cmd;
    logic   permitted, accept, reject;
    logic   tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic   erase_fire, verify_fire, unsec_pend;

    assign sys_rst_n = rst_n & por_n;
    assign cmd       = cmd_e'(cmd_code);

    dsu_cmd_filter u_filter (
        .cmd       (cmd),
        .secured   (secured),
        .prot_on   (prot_on),
        .permitted (permitted)
    );

    dsu_busy_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (INIT_CYC - 1),
        .MAX_VAL (MAX_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    dsu_nv_store #(
        .NBLK   (NBLK),
        .BIDX_W (BIDX_W)
    ) u_store (
        .clk        (clk),
        .por_n      (por_n),
        .erase_all  (erase_fire),
        .erase_open (unsec_pend),
        .prog_blk   (accept && (cmd == CMD_PROG_BLK)),
        .blk_idx    (cmd_data[BIDX_W-1:0]),
        .prog_sec   (accept && (cmd == CMD_PROG_SEC)),
        .sec_data   (cmd_data),
        .blk_erased (blk_erased),
        .sec_byte   (sec_byte)
    );

    // Request handling: only IDLE takes commands (R8)
    assign accept = cmd_valid && (state == ST_IDLE) && permitted;
    assign reject = cmd_valid && !((state == ST_IDLE) && permitted);

    // State register
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n)
            state <= ST_INIT;
        else
            state <= state_nx;
    end

    // Next state and strobes
    always_comb begin
        state_nx    = state;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        erase_fire  = 1'b0;
        verify_fire = 1'b0;
        unique case (state)
            ST_INIT: begin
                if (tmr_zero)
                    state_nx = ST_IDLE;
            end
            ST_IDLE: begin
                if (accept) begin
                    if (cmd == CMD_VERIFY_ALL) begin
                        state_nx = ST_VERIFY;
                    end else if (cmd == CMD_ERASE_ALL || cmd == CMD_UNSECURE) begin
                        state_nx = ST_ERASE;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(ERASE_CYC - 1);
                    end
                end
            end
            ST_VERIFY: begin
                state_nx    = ST_IDLE;
                verify_fire = 1'b1;
            end
            ST_ERASE: begin
                if (tmr_zero) begin
                    state_nx   = ST_IDLE;
                    erase_fire = 1'b1;
                end
            end
            default: state_nx = ST_INIT;
        endcase
    end

    // Security, protection and result registers
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            secured     <= 1'b1;
            prot_on     <= 1'b1;
            verify_pass <= 1'b0;
            acc_err     <= 1'b0;
            unsec_pend  <= 1'b0;
        end else begin
            acc_err <= reject;
            if (state == ST_INIT && tmr_zero)
                secured <= (sec_byte[1:0] != SEC_FIELD_OPEN);      // R1
            if (accept) begin
                unique case (cmd)
                    CMD_CLR_PROT:  prot_on    <= 1'b0;
                    CMD_SET_PROT:  prot_on    <= 1'b1;
                    CMD_UNSECURE:  unsec_pend <= 1'b1;
                    CMD_ERASE_ALL: unsec_pend <= 1'b0;
                    default: ;
                endcase
            end
            if (verify_fire) begin                                  // R5
                verify_pass <= &blk_erased;
                if (&blk_erased)
                    secured <= 1'b0;
            end
            if (erase_fire && unsec_pend)                           // R6
                secured <= 1'b0;
        end
    end

    // Output decode
    always_comb begin
        cmd_done = (state == ST_IDLE);
    end

    assert_busy_reject_R8: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (cmd_valid && !cmd_done) |=> acc_err);

    assert_locked_reject_R2: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (cmd_valid && cmd_done && secured && cmd_code >= 3'd5) |=> (acc_err && $stable(sec_byte)));

    assert_prot_guard_R3: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (cmd_valid && cmd_done && prot_on && (cmd_code == 3'd2 || cmd_code == 3'd4))
        |=> (acc_err && cmd_done));

    assert_zero_reject_R10: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (cmd_valid && cmd_code == 3'd0) |=> acc_err);

    assert_unlock_source_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $fell(secured) |-> ($past(state) == ST_VERIFY || $past(state) == ST_ERASE
                            || $past(state) == ST_INIT));
endmodule

// File: tb/dbg_sec_unlock_test.sv
`timescale 1ns/1ps
module dbg_sec_unlock_test;
    localparam int NB = 4;
    localparam int IC = 4;
    localparam int EC = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          por_n = 1'b0, rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_code = '0;
    logic [7:0]    cmd_data = '0;
    logic          cmd_done, acc_err, secured, prot_on, verify_pass;
    logic [NB-1:0] blk_erased;
    logic [7:0]    sec_byte;

    dbg_sec_unlock #(.NBLK(NB), .INIT_CYC(IC), .ERASE_CYC(EC)) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_data(cmd_data), .cmd_done(cmd_done),
        .acc_err(acc_err), .secured(secured), .prot_on(prot_on),
        .verify_pass(verify_pass), .blk_erased(blk_erased), .sec_byte(sec_byte)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;

    // scoreboard queues
    int           q_due[$];
    string        q_tag[$];
    logic [16:0]  q_exp[$];

    // reference model
    logic          m_sec = 1'b1, m_prot = 1'b1, m_vp = 1'b0;
    logic [NB-1:0] m_blk = '0;
    logic [7:0]    m_sb = '0;

    function automatic logic [16:0] snap(input logic done, input logic acc);
        return {m_sec, done, acc, m_vp, m_prot, m_blk, m_sb};
    endfunction

    task automatic push(input int due, input string tag, input logic [16:0] e);
        q_due.push_back(due);
        q_tag.push_back(tag);
        q_exp.push_back(e);
    endtask

    // monitor
    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] <= cyc) begin
            logic [16:0] act;
            act = {secured, cmd_done, acc_err, verify_pass, prot_on, blk_erased, sec_byte};
            checks++;
            if (q_due[0] < cyc) begin
                errors++;
                $display("FAIL %s: due cycle %0d missed, actual %h expected %h",
                         q_tag[0], q_due[0], act, q_exp[0]);
            end else if (act !== q_exp[0]) begin
                errors++;
                $display("FAIL %s: cycle %0d actual %h expected %h",
                         q_tag[0], cyc, act, q_exp[0]);
            end
            void'(q_due.pop_front());
            void'(q_tag.pop_front());
            void'(q_exp.pop_front());
        end
    end

    task automatic do_reset(input bit por, input string tag);
        int r;
        @(negedge clk);
        rst_n = 1'b0;
        if (por) por_n = 1'b0;
        cmd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (por) begin
            m_blk = '0;
            m_sb  = 8'h00;
        end
        m_prot = 1'b1; m_vp = 1'b0; m_sec = 1'b1;
        rst_n = 1'b1; por_n = 1'b1;
        r = cyc;
        push(r + IC - 1, tag, snap(1'b0, 1'b0));
        m_sec = (m_sb[1:0] != 2'b10);
        push(r + IC, tag, snap(1'b1, 1'b0));
        while (cyc < r + IC + 1) @(negedge clk);
    endtask

    task automatic issue(input logic [2:0] code, input logic [7:0] data,
                         input string tag, input bit poke);
        int c, last;
        bit ok;
        @(negedge clk);
        c = cyc;
        cmd_valid = 1'b1; cmd_code = code; cmd_data = data;
        ok = (code != 3'd0) && !(m_sec && code >= 3'd5)
             && !(m_prot && (code == 3'd2 || code == 3'd4));
        last = c + 1;
        if (!ok) begin
            push(c + 1, tag, snap(1'b1, 1'b1));
            push(c + 2, tag, snap(1'b1, 1'b0));
            last = c + 2;
        end else begin
            case (code)
                3'd1: begin
                    push(c + 1, tag, snap(1'b0, 1'b0));
                    m_vp = &m_blk;
                    if (&m_blk) m_sec = 1'b0;
                    push(c + 2, tag, snap(1'b1, 1'b0));
                    last = c + 2;
                end
                3'd2, 3'd4: begin
                    push(c + 1, tag, snap(1'b0, 1'b0));
                    if (poke) push(c + 3, "R8 busy request", snap(1'b0, 1'b1));
                    m_blk = '1;
                    m_sb  = (code == 3'd4) ? 8'hFE : 8'hFF;
                    if (code == 3'd4) m_sec = 1'b0;
                    push(c + EC + 1, tag, snap(1'b1, 1'b0));
                    last = c + EC + 1;
                end
                3'd3: begin m_prot = 1'b0; push(c + 1, tag, snap(1'b1, 1'b0)); end
                3'd5: begin m_blk[data[1:0]] = 1'b0; push(c + 1, tag, snap(1'b1, 1'b0)); end
                3'd6: begin m_sb = data; push(c + 1, tag, snap(1'b1, 1'b0)); end
                default: begin m_prot = 1'b1; push(c + 1, tag, snap(1'b1, 1'b0)); end
            endcase
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        if (poke) begin
            @(negedge clk);
            cmd_valid = 1'b1; cmd_code = 3'd3;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (cyc < last + 1) @(negedge clk);
    endtask

    task automatic finish_run();
        if (q_due.size() > 0) begin
            checks++; errors++;
            $display("FAIL queue: %0d pending items, actual 0 expected 0", q_due.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset(1'b1, "R1 R9 power-on start-up");
        issue(3'd6, 8'hFE, "R2 locked program security byte", 1'b0);
        issue(3'd7, 8'h00, "R2 locked set protection", 1'b0);
        issue(3'd5, 8'h01, "R2 locked program block", 1'b0);
        issue(3'd0, 8'h00, "R10 code zero", 1'b0);
        issue(3'd2, 8'h00, "R3 erase under protection", 1'b0);
        issue(3'd4, 8'h00, "R3 unsecure under protection", 1'b0);
        issue(3'd1, 8'h00, "R5 blank check failing", 1'b0);
        issue(3'd3, 8'h00, "R7 clear protection while locked", 1'b0);
        issue(3'd2, 8'h00, "R4 mass erase", 1'b1);
        issue(3'd1, 8'h00, "R5 blank check passing", 1'b0);
        issue(3'd5, 8'h02, "R7 program block", 1'b0);
        issue(3'd6, 8'hFE, "R7 program security byte", 1'b0);
        issue(3'd7, 8'h00, "R7 set protection", 1'b0);
        issue(3'd0, 8'h00, "R10 code zero unlocked", 1'b0);
        do_reset(1'b0, "R1 R9 reset comes up open");
        issue(3'd6, 8'h00, "R7 relock security byte", 1'b0);
        do_reset(1'b0, "R1 reset comes up locked");
        issue(3'd3, 8'h00, "R7 clear protection", 1'b0);
        issue(3'd4, 8'h00, "R6 one-step unsecure", 1'b1);
        issue(3'd0, 8'h00, "R10 code zero after unsecure", 1'b0);
        do_reset(1'b1, "R9 power-on clears store");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule